// File: doc/BRIEF.md
# Power Rail Sequencing Controller

This block is the clocked state machine that switches the regulators of a small power-management device on and off. It drives two step-down converter enables, one for the memory rail and one for the core rail, and five linear-regulator enables. It also drives an active-low reset output toward the host. A level on the wake input starts the power-up sequence. That input first passes through a synchronizer. The block then enables the rails one at a time: the memory converter, then the core converter, then the three fixed linear regulators. Each step waits on a timer. After the rails are up, the block can pulse the reset output low. It then waits for the host to take over through a separate hold input.

All delays are counted in clock ticks and set by parameters. One shared down-counter times every step. The step after the memory converter also waits for a power-good indication from that rail. When the host releases hold, every rail turns off at once except the memory converter, which stays on for a fixed delay. If wake is withdrawn before hold is taken, the sequence aborts through the same power-down path. An under-voltage or over-temperature flag removes all enables at once, in the same cycle, from any state. The flag also returns the machine to its idle state.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rstN` is low, and after reset until a wake request arrives, all rail enables are 0 and `rstOutN` is 1.
- R2: `memEn` rises at the (SYNC_STAGES+2)-th rising clock edge after `wakeReq` goes high. No other rail is enabled before it.
- R3: While in the memory ramp step, no later rail turns on as long as `memGood` is low. `coreEn` rises at the SETTLE_CYC-th rising edge counted from the first edge that samples `memGood` high.
- R4: `ldoEn` goes from 3'b000 to 3'b111 in one cycle, exactly CORE_CYC cycles after the core step begins. The three LDO enables never differ from one another.
- R5: With PULSE_EN=1, `rstOutN` goes low LDO_CYC cycles after `ldoEn` rises and stays low for exactly RST_CYC cycles. With PULSE_EN=0, `rstOutN` never goes low.
- R6: Once the reset step has ended, the on state is entered SYNC_STAGES+1 edges after `holdReq` rises. In the on state, a falling `wakeReq` has no effect on any output.
- R7: `coreEn` is high only when the sequence allows the core rail and `coreExtEn` and `coreRegEn` are both 1. A change on either pin shows on `coreEn` in the same cycle. `coreRegEn` is meant to come from a register bit whose reset value is 1.
- R8: SYNC_STAGES+1 edges after `holdReq` falls in the on state, every enable except `memEn` is 0. `memEn` falls OFF_CYC cycles after that.
- R9: If `wakeReq` falls before the on state is reached, the block runs the R8 power-down path. All rails except `memEn` drop SYNC_STAGES+1 edges after the fall, and `memEn` drops OFF_CYC cycles later.
- R10: `auxEn[1:0]` (the LDO4 and LDO5 enables) follow `auxRegEn[1:0]` only in the on state. In every other state they are 0, whatever `auxRegEn` holds.
- R11: A high `uvloFlag` or `otFlag` drives every enable to 0 and `rstOutN` to 1 in the same cycle, from any state. The machine is idle at the next edge, and it stays idle after the flag clears unless `wakeReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (one tick of the delay counters) |
| rstN | input | 1 | Asynchronous active-low reset |
| wakeReq | input | 1 | Asynchronous power-on request level |
| holdReq | input | 1 | Asynchronous host power-hold level |
| memGood | input | 1 | Memory converter has reached 90% of its target |
| coreExtEn | input | 1 | External pin enable for the core converter |
| coreRegEn | input | 1 | Register-bit enable for the core converter |
| auxRegEn | input | 2 | Register enables for LDO4 (bit 0) and LDO5 (bit 1) |
| uvloFlag | input | 1 | Under-voltage lockout active |
| otFlag | input | 1 | Over-temperature shutdown active |
| memEn | output | 1 | Memory converter (DC/DC2) enable |
| coreEn | output | 1 | Core converter (DC/DC1) enable |
| ldoEn | output | 3 | LDO1..LDO3 enables (bit 0 = LDO1) |
| auxEn | output | 2 | LDO4 (bit 0) and LDO5 (bit 1) enables |
| rstOutN | output | 1 | Active-low reset pulse to the host |

## Verification
The hardest conditions to reach are the fault flag landing inside a particular timed step, and wake being withdrawn partway through the ramp. Each of them needs the whole synchronized power-up timeline to be driven up to an exact cycle first. The bench reaches every stopping point by replaying the same timeline. It lands on the memory ramp, the LDO step, the reset pulse, the on state and the power-down delay in turn. In each, it raises under-voltage in one pass and over-temperature in another, then checks that the rails fall in that same cycle and stay down after the flag clears. The abort case drops wake during the core step, whose length is set longer than the synchronizer latency. That way the exit is provably caused by the withdrawal and not by the timer.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_SYNC,
    ST_RAMP_MEM,
    ST_RAMP_CORE,
    ST_RAMP_LDO,
    ST_RST_PULSE,
    ST_WAIT_HOLD,
    ST_ON,
    ST_OFF_DELAY
  } seq_state_e;

  typedef enum logic [2:0] {
    DLY_SETTLE,
    DLY_CORE,
    DLY_LDO,
    DLY_RST,
    DLY_OFF
  } dly_sel_e;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic     load;
    dly_sel_e sel;
  } tmr_ctl_t;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer
  import pwr_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 100,
  parameter int CORE_CYC    = 1000,
  parameter int LDO_CYC     = 10000,
  parameter int RST_CYC     = 1000,
  parameter int OFF_CYC     = 100
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wakeReq,
  input  logic     holdReq,
  input  tmr_ctl_t tmrCtl,
  output logic     wakeSync,
  output logic     holdSync,
  output logic     timerDone
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_DLY = maxOf(maxOf(maxOf(SETTLE_CYC, CORE_CYC), maxOf(LDO_CYC, RST_CYC)), OFF_CYC);
  localparam int CW      = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY);
  localparam int NSIG    = 2;

  // synchronizer chains, one per asynchronous level
  logic [NSIG-1:0] asyncIn;
  logic [NSIG-1:0] syncOut;
  assign asyncIn = {holdReq, wakeReq};

  genvar g;
  generate
    for (g = 0; g < NSIG; g++) begin : gSync
      logic [SYNC_STAGES-1:0] stageFf;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageFf <= '0;
        else       stageFf <= (stageFf << 1) | SYNC_STAGES'(asyncIn[g]);
      end
      assign syncOut[g] = stageFf[SYNC_STAGES-1];
    end
  endgenerate

  assign wakeSync = syncOut[0];
  assign holdSync = syncOut[1];

  // shared down-counter; a step of N cycles loads N-1
  logic [CW-1:0] cnt;
  logic [CW-1:0] loadVal;

  always_comb begin
    case (tmrCtl.sel)
      DLY_SETTLE: loadVal = CW'(SETTLE_CYC - 1);
      DLY_CORE:   loadVal = CW'(CORE_CYC - 1);
      DLY_LDO:    loadVal = CW'(LDO_CYC - 1);
      DLY_RST:    loadVal = CW'(RST_CYC - 1);
      DLY_OFF:    loadVal = CW'(OFF_CYC - 1);
      default:    loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (tmrCtl.load) cnt <= loadVal;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign timerDone = (cnt == '0);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter bit PULSE_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakeSync,
  input  logic       holdSync,
  input  logic       timerDone,
  input  logic       memGood,
  input  logic       coreExtEn,
  input  logic       coreRegEn,
  input  logic [1:0] auxRegEn,
  input  logic       uvloFlag,
  input  logic       otFlag,
  output tmr_ctl_t   tmrCtl,
  output logic       memEn,
  output logic       coreEn,
  output logic [2:0] ldoEn,
  output logic [1:0] auxEn,
  output logic       rstOutN
);

  seq_state_e state, nextState;
  logic fault;

  assign fault = uvloFlag | otFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    tmrCtl.load = 1'b0;
    tmrCtl.sel  = DLY_SETTLE;
    if (fault) begin
      nextState = ST_OFF;
    end else begin
      case (state)
        ST_OFF: if (wakeSync) nextState = ST_SYNC;
        ST_SYNC: begin
          if (wakeSync) begin
            nextState   = ST_RAMP_MEM;
            tmrCtl.load = 1'b1;
            tmrCtl.sel  = DLY_SETTLE;
          end else nextState = ST_OFF;
        end
        ST_RAMP_MEM: begin
          if (!wakeSync) begin
            nextState = ST_OFF_DELAY; tmrCtl.load = 1'b1; tmrCtl.sel = DLY_OFF;
          end else if (!memGood) begin
            tmrCtl.load = 1'b1; tmrCtl.sel = DLY_SETTLE;
          end else if (timerDone) begin
            nextState = ST_RAMP_CORE; tmrCtl.load = 1'b1; tmrCtl.sel = DLY_CORE;
          end
        end
        ST_RAMP_CORE: begin
          if (!wakeSync) begin
            nextState = ST_OFF_DELAY; tmrCtl.load = 1'b1; tmrCtl.sel = DLY_OFF;
          end else if (timerDone) begin
            nextState = ST_RAMP_LDO; tmrCtl.load = 1'b1; tmrCtl.sel = DLY_LDO;
          end
        end
        ST_RAMP_LDO: begin
          if (!wakeSync) begin
            nextState = ST_OFF_DELAY; tmrCtl.load = 1'b1; tmrCtl.sel = DLY_OFF;
          end else if (timerDone) begin
            if (PULSE_EN) begin
              nextState = ST_RST_PULSE; tmrCtl.load = 1'b1; tmrCtl.sel = DLY_RST;
            end else nextState = ST_WAIT_HOLD;
          end
        end
        ST_RST_PULSE: begin
          if (!wakeSync) begin
            nextState = ST_OFF_DELAY; tmrCtl.load = 1'b1; tmrCtl.sel = DLY_OFF;
          end else if (timerDone) nextState = ST_WAIT_HOLD;
        end
        ST_WAIT_HOLD: begin
          if (!wakeSync) begin
            nextState = ST_OFF_DELAY; tmrCtl.load = 1'b1; tmrCtl.sel = DLY_OFF;
          end else if (holdSync) nextState = ST_ON;
        end
        ST_ON: begin
          if (!holdSync) begin
            nextState = ST_OFF_DELAY; tmrCtl.load = 1'b1; tmrCtl.sel = DLY_OFF;
          end
        end
        ST_OFF_DELAY: if (timerDone) nextState = ST_OFF;
        default: nextState = ST_OFF;
      endcase
    end
  end

  logic memPhase, corePhase, ldoPhase;

  always_comb begin
    memPhase  = (state == ST_RAMP_MEM)  || (state == ST_RAMP_CORE) ||
                (state == ST_RAMP_LDO)  || (state == ST_RST_PULSE) ||
                (state == ST_WAIT_HOLD) || (state == ST_ON) ||
                (state == ST_OFF_DELAY);
    corePhase = (state == ST_RAMP_CORE) || (state == ST_RAMP_LDO) ||
                (state == ST_RST_PULSE) || (state == ST_WAIT_HOLD) ||
                (state == ST_ON);
    ldoPhase  = (state == ST_RAMP_LDO)  || (state == ST_RST_PULSE) ||
                (state == ST_WAIT_HOLD) || (state == ST_ON);
  end

  assign memEn   = memPhase & ~fault;
  assign coreEn  = corePhase & coreExtEn & coreRegEn & ~fault;
  assign ldoEn   = {3{ldoPhase & ~fault}};
  assign auxEn   = (state == ST_ON && !fault) ? auxRegEn : 2'b00;
  assign rstOutN = ~((state == ST_RST_PULSE) & ~fault);

  // a fault always lands the machine in the idle state
  assert_fault_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (uvloFlag || otFlag) |=> (state == ST_OFF));

  // power-good low holds the memory ramp step
  assert_mem_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RAMP_MEM && !memGood && wakeSync && !fault) |=> (state == ST_RAMP_MEM));

  // the memory rail delay runs until the shared timer expires
  assert_off_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF_DELAY && !timerDone && !fault) |=> (state == ST_OFF_DELAY));

  // the host hold keeps the on state
  assert_hold_on_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ON && holdSync && !fault) |=> (state == ST_ON));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 100,
  parameter int CORE_CYC    = 1000,
  parameter int LDO_CYC     = 10000,
  parameter int RST_CYC     = 1000,
  parameter int OFF_CYC     = 100,
  parameter bit PULSE_EN    = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakeReq,
  input  logic       holdReq,
  input  logic       memGood,
  input  logic       coreExtEn,
  input  logic       coreRegEn,
  input  logic [1:0] auxRegEn,
  input  logic       uvloFlag,
  input  logic       otFlag,
  output logic       memEn,
  output logic       coreEn,
  output logic [2:0] ldoEn,
  output logic [1:0] auxEn,
  output logic       rstOutN
);

  tmr_ctl_t tmrCtl;
  logic     wakeSync, holdSync, timerDone;

  pwr_seq_timer #(
    .SYNC_STAGES(SYNC_STAGES), .SETTLE_CYC(SETTLE_CYC), .CORE_CYC(CORE_CYC),
    .LDO_CYC(LDO_CYC), .RST_CYC(RST_CYC), .OFF_CYC(OFF_CYC)
  ) uTimer (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .holdReq(holdReq),
    .tmrCtl(tmrCtl), .wakeSync(wakeSync), .holdSync(holdSync),
    .timerDone(timerDone)
  );

  pwr_seq_fsm #(.PULSE_EN(PULSE_EN)) uFsm (
    .clk(clk), .rstN(rstN), .wakeSync(wakeSync), .holdSync(holdSync),
    .timerDone(timerDone), .memGood(memGood), .coreExtEn(coreExtEn),
    .coreRegEn(coreRegEn), .auxRegEn(auxRegEn), .uvloFlag(uvloFlag),
    .otFlag(otFlag), .tmrCtl(tmrCtl), .memEn(memEn), .coreEn(coreEn),
    .ldoEn(ldoEn), .auxEn(auxEn), .rstOutN(rstOutN)
  );

  // LDO1..3 move together and only on top of the memory rail
  assert_ldo_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ldoEn != 3'b000) |-> (memEn && ldoEn == 3'b111));

  // LDO4/5 only appear with the sequenced rails fully up
  assert_aux_in_on_R10: assert property (@(posedge clk) disable iff (!rstN)
    (auxEn != 2'b00) |-> (ldoEn == 3'b111 && memEn));

  // the reset pulse only happens with all sequenced LDOs up
  assert_pulse_rails_R5: assert property (@(posedge clk) disable iff (!rstN)
    !rstOutN |-> (ldoEn == 3'b111 && memEn));

endmodule

// File: tb/tb_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_seq_ctrl;

  localparam int S      = 2;
  localparam int SETTLE = 3;
  localparam int CORE   = 5;
  localparam int LDO    = 7;
  localparam int RSTC   = 4;
  localparam int OFFC   = 6;

  // vector order {memEn, coreEn, ldoEn[2:0], auxEn[1:0], rstOutN}
  localparam logic [7:0] V_OFF  = 8'b0000_0001;
  localparam logic [7:0] V_MEM  = 8'b1000_0001;
  localparam logic [7:0] V_CORE = 8'b1100_0001;
  localparam logic [7:0] V_LDO  = 8'b1111_1001;
  localparam logic [7:0] V_RST  = 8'b1111_1000;
  localparam logic [7:0] V_ON   = 8'b1111_1111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeReq = 0, holdReq = 0, memGood = 0, coreExtEn = 1, coreRegEn = 1;
  logic [1:0] auxRegEn = 2'b11;
  logic uvloFlag = 0, otFlag = 0;
  logic memEn, coreEn, rstOutN;
  logic [2:0] ldoEn;
  logic [1:0] auxEn;
  logic npMem, npCore, npRst;
  logic [2:0] npLdo;
  logic [1:0] npAux;
  logic [7:0] vec;

  int checks = 0, errors = 0, npLows = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwr_seq_ctrl #(.SYNC_STAGES(S), .SETTLE_CYC(SETTLE), .CORE_CYC(CORE),
    .LDO_CYC(LDO), .RST_CYC(RSTC), .OFF_CYC(OFFC), .PULSE_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .holdReq(holdReq),
    .memGood(memGood), .coreExtEn(coreExtEn), .coreRegEn(coreRegEn),
    .auxRegEn(auxRegEn), .uvloFlag(uvloFlag), .otFlag(otFlag),
    .memEn(memEn), .coreEn(coreEn), .ldoEn(ldoEn), .auxEn(auxEn),
    .rstOutN(rstOutN));

  pwr_seq_ctrl #(.SYNC_STAGES(S), .SETTLE_CYC(SETTLE), .CORE_CYC(CORE),
    .LDO_CYC(LDO), .RST_CYC(RSTC), .OFF_CYC(OFFC), .PULSE_EN(1'b0)) dutNoPulse (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .holdReq(holdReq),
    .memGood(memGood), .coreExtEn(coreExtEn), .coreRegEn(coreRegEn),
    .auxRegEn(auxRegEn), .uvloFlag(uvloFlag), .otFlag(otFlag),
    .memEn(npMem), .coreEn(npCore), .ldoEn(npLdo), .auxEn(npAux),
    .rstOutN(npRst));

  assign vec = {memEn, coreEn, ldoEn, auxEn, rstOutN};

  always @(negedge clk) if (rstN && !npRst) npLows++;

  task automatic chk(input logic [7:0] exp, input string tag);
    checks++;
    if (vec !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, vec, exp, $time);
    end
  endtask

  task automatic holdFor(input int n, input logic [7:0] exp, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(exp, tag);
    end
  endtask

  // old value for n-1 cycles, new value at the n-th
  task automatic step(input int n, input logic [7:0] oldV, input logic [7:0] newV,
                      input string tag);
    holdFor(n - 1, oldV, tag);
    holdFor(1, newV, tag);
  endtask

  task automatic upToCore();
    wakeReq = 1;
    step(S + 2, V_OFF, V_MEM, "R2 memory rail after sync");
    holdFor(3, V_MEM, "R3 no later rail without memGood");
    memGood = 1;
    step(SETTLE, V_MEM, V_CORE, "R3 core after settle");
  endtask

  task automatic coreToWait();
    step(CORE, V_CORE, V_LDO, "R4 LDO1-3 after core step");
    step(LDO, V_LDO, V_RST, "R5 reset pulse start");
    step(RSTC, V_RST, V_LDO, "R5 reset pulse width / R10 aux off");
  endtask

  task automatic waitToOn();
    holdFor(3, V_LDO, "R10 aux ignored while waiting");
    holdReq = 1;
    step(S + 1, V_LDO, V_ON, "R6 on after hold");
  endtask

  task automatic settleIdle();
    wakeReq = 0; holdReq = 0; memGood = 0;
    holdFor(S + 2, V_OFF, "R11 idle after fault");
    uvloFlag = 0; otFlag = 0;
    holdFor(S + 2, V_OFF, "R11 stays idle without wake");
  endtask

  task automatic faultAt(input int stage, input bit useOt);
    case (stage)
      0: begin wakeReq = 1; step(S + 2, V_OFF, V_MEM, "R2 memory rail"); end
      1: begin upToCore(); step(CORE, V_CORE, V_LDO, "R4 LDO step"); end
      2: begin
        upToCore(); step(CORE, V_CORE, V_LDO, "R4 LDO step");
        step(LDO, V_LDO, V_RST, "R5 reset pulse");
      end
      default: begin
        upToCore(); coreToWait(); waitToOn();
        if (stage == 4) begin
          holdReq = 0;
          step(S + 1, V_ON, V_MEM, "R8 power-down start");
        end
      end
    endcase
    if (useOt) otFlag = 1; else uvloFlag = 1;
    #1 chk(V_OFF, useOt ? "R11 over-temperature immediate" : "R11 under-voltage immediate");
    settleIdle();
  endtask

  initial begin
    #(200_000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    holdFor(3, V_OFF, "R1 during reset");
    rstN = 1;
    holdFor(4, V_OFF, "R1 idle after reset");

    // full sequence, hold, wake ignored in on state, core pin gating, power-down
    upToCore();
    coreToWait();
    waitToOn();
    wakeReq = 0;
    holdFor(S + 4, V_ON, "R6 wake fall ignored in on state");
    coreExtEn = 0; #1 chk(8'b1011_1111, "R7 external pin low");
    coreExtEn = 1; coreRegEn = 0; #1 chk(8'b1011_1111, "R7 register bit low");
    coreRegEn = 1; #1 chk(V_ON, "R7 both high");
    auxRegEn = 2'b01; #1 chk(8'b1111_1011, "R10 aux follows register in on");
    auxRegEn = 2'b11;
    holdReq = 0;
    step(S + 1, V_ON, V_MEM, "R8 rails drop, memory stays");
    step(OFFC, V_MEM, V_OFF, "R8 memory delay");
    holdFor(3, V_OFF, "R8 stays off");
    checks++;
    if (npLows != 0) begin
      errors++;
      $display("FAIL R5 pulse disabled: got %0d low cycles expected 0", npLows);
    end

    // abort during the core step
    memGood = 0;
    upToCore();
    wakeReq = 0;
    step(S + 1, V_CORE, V_MEM, "R9 abort drops rails");
    step(OFFC, V_MEM, V_OFF, "R9 abort memory delay");
    memGood = 0;
    holdFor(S + 2, V_OFF, "R9 idle after abort");

    // fault from every stopping point, both fault sources
    for (int st = 0; st < 5; st++) begin
      for (int f = 0; f < 2; f++) faultAt(st, f[0]);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule